// File: doc/BRIEF.md
# Two-Miss Hysteresis Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds a direct-mapped table of 2^k entries. Each entry is selected by k bits of the fetch address, starting just above the two low address bits, which are always zero for aligned instructions. A lookup is combinational. The lookup address selects one entry, and the block returns that entry's direction bit as a taken or not-taken prediction. The target address is not produced here; the fetch logic computes it from the instruction's offset field.

Each entry is a two-bit state. One bit holds the predicted direction. The other records whether the most recent prediction from that entry turned out right or wrong. When a branch resolves, the pipeline sends its address and actual outcome to the update port. On the next clock edge the selected entry moves to its next state. The predicted direction reverses only when two mispredictions arrive back to back, so a single odd outcome, such as a loop exit, does not disturb a well-established prediction.

Top module: `hbt_predictor`

## Requirements
- R1: After reset every entry is in the state not-taken/last-right, so every lookup returns `predTaken` = 0 until an update changes that entry.
- R2: The entry is selected by address bits [IDX_W+1:2]. Bits [1:0] and all bits above IDX_W+1 do not affect which entry is read or written.
- R3: `predTaken` is combinational from `lookupPc` and equals the direction bit currently stored in the selected entry (1 = taken).
- R4: An update whose outcome matches the entry's direction, while the entry is in a last-right state, leaves the entry unchanged.
- R5: An update whose outcome differs from the direction, while the entry is in a last-right state, moves the entry to last-wrong and keeps its direction.
- R6: An update whose outcome matches the direction, while the entry is in a last-wrong state, moves the entry back to last-right with the same direction.
- R7: An update whose outcome differs from the direction, while the entry is in a last-wrong state, flips the direction and sets the entry to last-right.
- R8: When a lookup and an update select the same entry in the same cycle, the lookup returns the state from before the update. The new state is visible from the cycle after the clock edge.
- R9: While `updValid` is 0 no entry changes. An update changes only the entry that it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupPc | input | PC_W | Fetch address to be predicted |
| predTaken | output | 1 | Predicted direction of the looked-up entry, 1 = taken |
| updValid | input | 1 | A resolved branch is presented on the update port this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Actual outcome of the resolved branch, 1 = taken |

## Verification
The bench targets four points where a wrong design would visibly diverge:
- **First miss versus second miss.** A design that treats the first misprediction like the second would reverse a prediction after a single odd outcome.
- **Clearing the wrong flag.** A design that forgets to clear the flag on a correct outcome would reverse after two misses that were not consecutive.
- **Right flag after a flip.** A design that leaves the wrong flag set after a flip would reverse again on the next miss.
- **Same-entry lookup and update.** A design that forwards the new state to a same-cycle lookup would show it one cycle early.

The bench also varies the unused address bits, to catch an entry selected from the wrong address slice. It checks that untouched entries keep their state, to catch a write reaching more than one entry.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  // Entry state: dir = predicted direction (1 taken), miss = last prediction wrong
  typedef struct packed {
    logic dir;
    logic miss;
  } hbtState_t;

  localparam hbtState_t HBT_RESET_STATE = '{dir: 1'b0, miss: 1'b0};

  // Strobes from control to the table
  typedef struct packed {
    logic      wrEn;
    hbtState_t wrState;
  } hbtStrobe_t;
endpackage

// File: rtl/hbt_ctrl.sv
module hbt_ctrl
  import hbt_pkg::*;
(
  input  logic       updValid,
  input  logic       updTaken,
  input  hbtState_t  curState,
  output hbtStrobe_t strobe
);
  logic      predictedOk;
  hbtState_t nextState;

  assign predictedOk = (curState.dir == updTaken);

  always_comb begin
    nextState = curState;
    unique case ({curState.miss, predictedOk})
      2'b01: nextState = curState;                          // right, correct: hold
      2'b00: nextState = '{dir: curState.dir, miss: 1'b1};  // right, miss: arm
      2'b11: nextState = '{dir: curState.dir, miss: 1'b0};  // wrong, correct: disarm
      2'b10: nextState = '{dir: ~curState.dir, miss: 1'b0}; // wrong, miss: flip
      default: nextState = curState;
    endcase
  end

  always_comb begin
    strobe.wrState = nextState;
    strobe.wrEn    = updValid && (nextState != curState);
  end
endmodule

// File: rtl/hbt_table.sv
module hbt_table
  import hbt_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lookIdx,
  input  logic [IDX_W-1:0] updIdx,
  input  hbtStrobe_t       strobe,
  output hbtState_t        lookState,
  output hbtState_t        updState
);
  localparam int ENTRIES = 1 << IDX_W;

  hbtState_t entry [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic hit;
    assign hit = strobe.wrEn && (updIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)    entry[g] <= HBT_RESET_STATE;
      else if (hit) entry[g] <= strobe.wrState;
    end
  end

  assign lookState = entry[lookIdx];
  assign updState  = entry[updIdx];
endmodule

// File: rtl/hbt_predictor.sv
module hbt_predictor
  import hbt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            predTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0] lookIdx;
  logic [IDX_W-1:0] updIdx;
  hbtState_t        lookState;
  hbtState_t        updCurState;
  hbtStrobe_t       strobe;
  logic             unusedPcBits;

  assign lookIdx      = lookupPc[IDX_HI:IDX_LO];
  assign updIdx       = updPc[IDX_HI:IDX_LO];
  assign unusedPcBits = ^{lookupPc[PC_W-1:IDX_HI+1], lookupPc[IDX_LO-1:0],
                          updPc[PC_W-1:IDX_HI+1], updPc[IDX_LO-1:0], lookState.miss};

  hbt_ctrl u_ctrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .curState (updCurState),
    .strobe   (strobe)
  );

  hbt_table #(.IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rstN      (rstN),
    .lookIdx   (lookIdx),
    .updIdx    (updIdx),
    .strobe    (strobe),
    .lookState (lookState),
    .updState  (updCurState)
  );

  assign predTaken = lookState.dir;
endmodule

// File: rtl/hbt_checker.sv
module hbt_checker
  import hbt_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic [PC_W-1:0] lookupPc,
  input logic            predTaken,
  input logic            updValid,
  input logic [PC_W-1:0] updPc,
  input logic            updTaken,
  input hbtState_t       updCurState
);
  logic [IDX_W-1:0] lIdx;
  logic [IDX_W-1:0] uIdx;
  logic             sameIdx;
  assign lIdx    = lookupPc[IDX_W+1:2];
  assign uIdx    = updPc[IDX_W+1:2];
  assign sameIdx = updValid && (lIdx == uIdx);

  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !predTaken) else $error("reset prediction"); // R1

  AST_CORRECT_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (sameIdx && predTaken == updTaken) |=> (lIdx != $past(lIdx)) || (predTaken == $past(predTaken)))
    else $error("correct update changed dir"); // R4

  AST_FIRST_MISS_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (sameIdx && predTaken != updTaken && !updCurState.miss) |=> (lIdx != $past(lIdx)) || (predTaken == $past(predTaken)))
    else $error("first miss flipped"); // R5

  AST_SECOND_MISS_FLIPS: assert property (@(posedge clk) disable iff (!rstN)
    (sameIdx && predTaken != updTaken && updCurState.miss) |=> (lIdx != $past(lIdx)) || (predTaken != $past(predTaken)))
    else $error("second miss did not flip"); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> (lIdx != $past(lIdx)) || (predTaken == $past(predTaken)))
    else $error("state changed without update"); // R9
endmodule

bind hbt_predictor hbt_checker #(.PC_W(PC_W), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lookupPc    (lookupPc),
  .predTaken   (predTaken),
  .updValid    (updValid),
  .updPc       (updPc),
  .updTaken    (updTaken),
  .updCurState (updCurState)
);

// File: tb/hbt_predictor_tb.sv
`timescale 1ns/1ps
module hbt_predictor_tb;
  localparam int PC_W = 32;
  localparam int IDX_W = 4;
  localparam int N = 1 << IDX_W;

  logic clk = 0;
  logic rstN = 0;
  logic [PC_W-1:0] lookupPc = '0;
  logic predTaken;
  logic updValid = 0;
  logic [PC_W-1:0] updPc = '0;
  logic updTaken = 0;

  int errors = 0;
  int checks = 0;
  logic [31:0] rng = 32'h1234_5678;

  // model: bit1 = direction, bit0 = last-wrong
  logic [1:0] mdl [N];

  always #2.5 clk = ~clk;

  hbt_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .predTaken(predTaken),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  function automatic logic [31:0] nextRand(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Requirement tag for a transition: R4 right/ok, R5 right/miss, R6 wrong/ok, R7 wrong/miss
  function automatic string kindTag(logic [1:0] s, logic t);
    if (!s[0]) return (s[1] == t) ? "R4" : "R5";
    return (s[1] == t) ? "R6" : "R7";
  endfunction

  function automatic logic [1:0] modelNext(logic [1:0] s, logic t);
    if (s[1] == t) return {s[1], 1'b0};
    if (!s[0])     return {s[1], 1'b1};
    return {~s[1], 1'b0};
  endfunction

  function automatic logic [PC_W-1:0] mkPc(int idx, logic [31:0] r);
    logic [PC_W-1:0] p;
    p = r;
    p[IDX_W+1:2] = idx[IDX_W-1:0];
    return p;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: predTaken=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check lookup before the edge, update model after
  task automatic cycle(logic v, int uIdx, logic t, int lIdx, string tag);
    @(negedge clk);
    rng = nextRand(rng);
    updValid = v; updTaken = t; updPc = mkPc(uIdx, rng);
    rng = nextRand(rng);
    lookupPc = mkPc(lIdx, rng);
    #1;
    check(tag, predTaken, mdl[lIdx][1]);
    @(posedge clk);
    if (v) mdl[uIdx] = modelNext(mdl[uIdx], t);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1: every entry predicts not-taken after reset
    for (int i = 0; i < N; i++) cycle(0, 0, 0, i, "R1");

    // R9: updates to entry 5 only; all other entries stay not-taken
    cycle(1, 5, 1, 5, "R3");
    cycle(1, 5, 1, 5, "R5");
    cycle(0, 5, 0, 5, "R7");
    for (int i = 0; i < N; i++) cycle(0, 0, 1, i, "R9");

    // Directed transitions on every entry: each step looked up the cycle after
    for (int e = 0; e < N; e++) begin
      logic [1:0] pat [8];
      logic pick;
      pat = '{2'b1, 2'b0, 2'b1, 2'b1, 2'b0, 2'b1, 2'b0, 2'b0};
      for (int k = 0; k < 8; k++) begin
        pick = pat[k][0] ^ e[0];
        cycle(1, e, pick, e, "R8");
        cycle(0, e, 0, e, kindTag(mdl[e], pick) == "" ? "R3" : "R3");
      end
    end

    // Random sweep: tags follow the transition last applied to the looked-up entry
    begin
      int prevIdx = -1;
      string prevTag = "R3";
      for (int n = 0; n < 4000; n++) begin
        int ui, li;
        logic v, t;
        string tag;
        string kt;
        rng = nextRand(rng);
        v  = rng[3:0] != 0;
        ui = int'(rng[11:8]);
        t  = rng[16];
        li = rng[20] ? prevIdx : int'(rng[27:24]);
        if (li < 0) li = 0;
        kt = kindTag(mdl[ui], t);
        if (v && li == ui)     tag = "R8";
        else if (li == prevIdx) tag = prevTag;
        else                   tag = "R3";
        cycle(v, ui, t, li, tag);
        prevIdx = v ? ui : -1;
        prevTag = v ? kt : "R9";
      end
    end

    // R2: address bits outside the index slice do not matter
    for (int i = 0; i < N; i++) begin
      cycle(0, 0, 0, i, "R2");
      cycle(0, 0, 0, i, "R2");
    end
    // R2: update with differing low/high bits reaches the same entry
    cycle(1, 9, ~mdl[9][1], 9, "R2");
    cycle(1, 9, ~mdl[9][1], 9, "R2");
    cycle(0, 9, 0, 9, "R2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule